// File: doc/BRIEF.md
# Indirect Configuration Access Engine

This engine turns a single configuration read or write request into a two-phase access on a pair of downstream register ports. A request gives a bus number, a device/function byte, a 12-bit register offset, an access length and write data. The engine first writes a 32-bit address word to an address port. It then makes one sized access on a data port, with the byte lane taken from the low offset bits. When the access ends, it reports the status and the read data through a one-cycle done pulse.

A small set of mode flags, together with the root bus number and the controller's own bus number, is loaded while the engine is idle. The flags control five things:

- packing of extended offset bits into the address word;
- marking of type-1 cycles;
- byte order of the address word;
- refusal of requests when no link is present;
- two write quirks that rewrite the data sent to specific registers.

Requests are taken one at a time through a valid/ready handshake.

Top module: `cfg_indirect_engine`

## Requirements
- R1: The address word has bit 31 set and bits 30:28 and bit 1 clear. Bits 23:16 hold the effective bus, bits 15:8 hold the device/function byte, and bits 7:2 hold offset bits 7:2.
- R2: When mode bit 0 (extended register) is set, address bits 27:24 carry offset bits 11:8. When it is clear, those bits are zero.
- R3: When mode bit 1 (type marking) is set and the requested bus differs from the root bus, address bit 0 is 1. In every other case it is 0.
- R4: A request on the root bus puts the configured own bus number into bits 23:16. Any other request puts its own bus number there.
- R5: When mode bit 3 (no link) is set, a request is refused if it is not on the root bus or its device/function byte is nonzero. A refused request ends with done_status=1 and read data 0, and makes no port access. Every other request ends with done_status=0.
- R6: The data access uses lane = offset[1:0]. A length of 1 gives strobe 0001b, a length of 2 gives 0011b, and any other length gives 1111b; the strobe is shifted left by the lane and truncated to 4 bits. Write data is shifted left by 8 times the lane. Read data is the port word shifted right by 8 times the lane and masked to the access size, so it is zero-extended. A write returns read data 0.
- R7: The address port write (port_sel=0, full strobe) is acknowledged before the data port access (port_sel=1) begins. When mode bit 2 is set, the address word is sent byte-reversed. Data accesses are never byte-reversed.
- R8: req_ready is high only when the engine is idle. Each accepted request yields exactly one single-cycle done pulse, after which req_ready returns high.
- R9: cfg_load latches the mode, root bus and own bus only while the engine is idle. A load presented while a request is in flight is ignored.
- R10: When mode bit 4 is set, a write to offset 0x018 on the root bus has the low byte of its data cleared before it is placed on the lanes.
- R11: When mode bit 5 is set, a write to offset 0x00C has its data forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Latch mode and bus numbers (effective when idle) |
| cfg_mode | input | 6 | Mode flags: bit0 extended reg, bit1 type mark, bit2 big-endian address, bit3 no link, bit4 primary clear, bit5 cache line zero |
| cfg_root_bus | input | 8 | Root bus number |
| cfg_own_bus | input | 8 | Controller's own bus number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device/function byte |
| req_offset | input | 12 | Register offset |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| port_valid | output | 1 | Downstream access active |
| port_sel | output | 1 | 0 = address port, 1 = data port |
| port_write | output | 1 | Access direction |
| port_lane | output | 2 | Byte lane offset on the data port |
| port_be | output | 4 | Byte strobes |
| port_wdata | output | 32 | Downstream write word |
| port_ack | input | 1 | Downstream access complete |
| port_rdata | input | 32 | Downstream read word, valid with port_ack |
| done | output | 1 | Request complete, one cycle |
| done_status | output | 1 | 0 = success, 1 = device not found |
| done_rdata | output | 32 | Read result |

## Verification
The bench aims at the places where the engine's paths meet. One case is a root-bus request in no-link mode with device/function zero, which must pass while its neighbours are refused. A filter that tested only the bus would let non-zero functions through and produce port traffic where none is expected. It also drives halfword and byte accesses at lanes 1 to 3 and lengths 0, 3 and 4. A wrong shift or truncation there shows up as misplaced strobes or as read data that is not zero-extended. It writes to offsets 0x018 and 0x00C with the quirk flags on, off, and on a non-root bus, which catches a quirk applied too widely or not at all. It also presents a mode load while a request is in flight. A design that latched that load would corrupt the address word of the current request or of the next one.

// File: rtl/cfg_idx_pkg.sv
package cfg_idx_pkg;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int OFF_W   = 12;
  localparam int DATA_W  = 32;
  localparam int LEN_W   = 3;
  localparam int MODE_W  = 6;
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);

  localparam logic [OFF_W-1:0] OFF_PRIMARY   = 12'h018;
  localparam logic [OFF_W-1:0] OFF_CACHELINE = 12'h00C;

  // bit 0 is ext_reg, bit 5 is zero_cacheline
  typedef struct packed {
    logic zero_cacheline;
    logic clear_primary;
    logic link_absent;
    logic addr_big_endian;
    logic mark_type1;
    logic ext_reg;
  } mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_ADDR, ST_DATA, ST_DONE
  } state_t;

  function automatic logic [DATA_W-1:0] compose_word(
    input logic               ext,
    input logic [BUS_W-1:0]   bus,
    input logic [DEVFN_W-1:0] devfn,
    input logic [OFF_W-1:0]   off,
    input logic               type1
  );
    compose_word = {1'b1, 3'b000, (ext ? off[11:8] : 4'h0),
                    bus, devfn, off[7:2], 1'b0, type1};
  endfunction

  function automatic logic [LANES-1:0] size_strobe(input logic [LEN_W-1:0] len);
    case (len)
      3'd1:    size_strobe = LANES'(1);
      3'd2:    size_strobe = LANES'(3);
      default: size_strobe = '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] strobe_to_mask(input logic [LANES-1:0] s);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{s[i]}};
    return m;
  endfunction
endpackage

// File: rtl/cfg_req_filter.sv
module cfg_req_filter
  import cfg_idx_pkg::*;
(
  input  logic               link_absent,
  input  logic               mark_type1,
  input  logic [BUS_W-1:0]   root_bus,
  input  logic [BUS_W-1:0]   own_bus,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  output logic               is_root,
  output logic               reject,
  output logic [BUS_W-1:0]   bus_eff,
  output logic               type1
);
  always_comb begin
    is_root = (bus == root_bus);
    reject  = link_absent && (!is_root || (devfn != '0));
    bus_eff = is_root ? own_bus : bus;
    type1   = mark_type1 && !is_root;
  end
endmodule

// File: rtl/cfg_addr_word.sv
module cfg_addr_word
  import cfg_idx_pkg::*;
(
  input  logic               ext_reg,
  input  logic               big_endian,
  input  logic [BUS_W-1:0]   bus_eff,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFF_W-1:0]   off,
  input  logic               type1,
  output logic [DATA_W-1:0]  word_out
);
  logic [DATA_W-1:0] native;
  logic [DATA_W-1:0] reversed;

  assign native = compose_word(ext_reg, bus_eff, devfn, off, type1);

  for (genvar b = 0; b < LANES; b++) begin : g_rev
    assign reversed[8*b +: 8] = native[8*(LANES-1-b) +: 8];
  end

  assign word_out = big_endian ? reversed : native;
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_idx_pkg::*;
(
  input  logic              clear_primary,
  input  logic              zero_cacheline,
  input  logic              is_root,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] port_rdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_out,
  output logic [DATA_W-1:0] rdata_out
);
  logic [LANE_W-1:0]    lane;
  logic [LANES-1:0]     strobe;
  logic [2*LANES-1:0]   be_wide;
  logic [DATA_W-1:0]    fixed;
  logic [LANE_W+2:0]    shamt;

  assign lane   = off[LANE_W-1:0];
  assign strobe = size_strobe(len);
  assign shamt  = {lane, 3'b000};

  always_comb begin
    fixed = wdata;
    if (clear_primary && is_root && (off == OFF_PRIMARY)) fixed[7:0] = 8'h00;
    if (zero_cacheline && (off == OFF_CACHELINE))         fixed = '0;
  end

  assign be_wide   = {{LANES{1'b0}}, strobe} << lane;
  assign be        = be_wide[LANES-1:0];
  assign wdata_out = fixed << shamt;
  assign rdata_out = (port_rdata >> shamt) & strobe_to_mask(strobe);
endmodule

// File: rtl/cfg_indirect_engine.sv
module cfg_indirect_engine
  import cfg_idx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [MODE_W-1:0]  cfg_mode,
  input  logic [BUS_W-1:0]   cfg_root_bus,
  input  logic [BUS_W-1:0]   cfg_own_bus,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               port_valid,
  output logic               port_sel,
  output logic               port_write,
  output logic [LANE_W-1:0]  port_lane,
  output logic [LANES-1:0]   port_be,
  output logic [DATA_W-1:0]  port_wdata,
  input  logic               port_ack,
  input  logic [DATA_W-1:0]  port_rdata,
  output logic               done,
  output logic               done_status,
  output logic [DATA_W-1:0]  done_rdata
);
  state_t             state;
  mode_t              mode_q;
  logic [BUS_W-1:0]   root_q, own_q;
  logic               wr_q;
  logic [BUS_W-1:0]   bus_q;
  logic [DEVFN_W-1:0] devfn_q;
  logic [OFF_W-1:0]   off_q;
  logic [LEN_W-1:0]   len_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               status_q;
  logic [DATA_W-1:0]  rdata_q;

  // named events for the checker
  logic              ev_accept, ev_reject, ev_addr_done, ev_data_done;
  logic [MODE_W-1:0] mode_flags;

  logic               is_root, reject, type1;
  logic [BUS_W-1:0]   bus_eff;
  logic [DATA_W-1:0]  addr_word, lane_wdata, lane_rdata;
  logic [LANES-1:0]   lane_be;

  cfg_req_filter u_filter (
    .link_absent (mode_q.link_absent),
    .mark_type1  (mode_q.mark_type1),
    .root_bus    (root_q),
    .own_bus     (own_q),
    .bus         (bus_q),
    .devfn       (devfn_q),
    .is_root     (is_root),
    .reject      (reject),
    .bus_eff     (bus_eff),
    .type1       (type1)
  );

  cfg_addr_word u_addr (
    .ext_reg    (mode_q.ext_reg),
    .big_endian (mode_q.addr_big_endian),
    .bus_eff    (bus_eff),
    .devfn      (devfn_q),
    .off        (off_q),
    .type1      (type1),
    .word_out   (addr_word)
  );

  cfg_lane_unit u_lane (
    .clear_primary  (mode_q.clear_primary),
    .zero_cacheline (mode_q.zero_cacheline),
    .is_root        (is_root),
    .off            (off_q),
    .len            (len_q),
    .wdata          (wdata_q),
    .port_rdata     (port_rdata),
    .be             (lane_be),
    .wdata_out      (lane_wdata),
    .rdata_out      (lane_rdata)
  );

  assign req_ready    = (state == ST_IDLE);
  assign ev_accept    = req_ready && req_valid;
  assign ev_reject    = (state == ST_DECIDE) && reject;
  assign ev_addr_done = (state == ST_ADDR) && port_ack;
  assign ev_data_done = (state == ST_DATA) && port_ack;
  assign mode_flags   = mode_q;

  always_comb begin
    port_valid = (state == ST_ADDR) || (state == ST_DATA);
    port_sel   = (state == ST_DATA);
    if (state == ST_DATA) begin
      port_write = wr_q;
      port_lane  = off_q[LANE_W-1:0];
      port_be    = lane_be;
      port_wdata = wr_q ? lane_wdata : '0;
    end else begin
      port_write = (state == ST_ADDR);
      port_lane  = '0;
      port_be    = (state == ST_ADDR) ? '1 : '0;
      port_wdata = (state == ST_ADDR) ? addr_word : '0;
    end
  end

  assign done        = (state == ST_DONE);
  assign done_status = status_q;
  assign done_rdata  = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      root_q <= '0;
      own_q  <= '0;
    end else if (req_ready && cfg_load) begin
      mode_q <= mode_t'(cfg_mode);
      root_q <= cfg_root_bus;
      own_q  <= cfg_own_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wr_q     <= 1'b0;
      bus_q    <= '0;
      devfn_q  <= '0;
      off_q    <= '0;
      len_q    <= '0;
      wdata_q  <= '0;
      status_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_accept) begin
          wr_q    <= req_write;
          bus_q   <= req_bus;
          devfn_q <= req_devfn;
          off_q   <= req_offset;
          len_q   <= req_len;
          wdata_q <= req_wdata;
          state   <= ST_DECIDE;
        end
        ST_DECIDE: begin
          rdata_q  <= '0;
          status_q <= reject;
          state    <= reject ? ST_DONE : ST_ADDR;
        end
        ST_ADDR: if (ev_addr_done) state <= ST_DATA;
        ST_DATA: if (ev_data_done) begin
          rdata_q <= wr_q ? '0 : lane_rdata;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_indirect_engine_chk.sv
module cfg_indirect_engine_chk
  import cfg_idx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              done_status,
  input logic              port_valid,
  input logic              port_sel,
  input logic [LANES-1:0]  port_be,
  input logic              wd_b31,
  input logic              wd_b7,
  input logic [MODE_W-1:0] mode_flags,
  input logic              ev_accept,
  input logic              ev_reject,
  input logic              ev_addr_done
);
  AST_ADDR_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && port_sel && !$past(port_valid && port_sel)) |-> $past(ev_addr_done)); // R7

  AST_ENABLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && !port_sel) |-> (mode_flags[2] ? wd_b7 : wd_b31)); // R1

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (done && done_status && !port_valid)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready)); // R8

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(mode_flags)); // R9

  AST_DATA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (port_valid && port_sel) |-> (port_be != '0)); // R6
endmodule

bind cfg_indirect_engine cfg_indirect_engine_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .done         (done),
  .done_status  (done_status),
  .port_valid   (port_valid),
  .port_sel     (port_sel),
  .port_be      (port_be),
  .wd_b31       (port_wdata[31]),
  .wd_b7        (port_wdata[7]),
  .mode_flags   (mode_flags),
  .ev_accept    (ev_accept),
  .ev_reject    (ev_reject),
  .ev_addr_done (ev_addr_done)
);

// File: tb/test_cfg_indirect_engine.sv
module test_cfg_indirect_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [5:0]  cfg_mode = '0;
  logic [7:0]  cfg_root_bus = '0, cfg_own_bus = '0;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_wdata = '0;
  logic        port_valid, port_sel, port_write;
  logic [1:0]  port_lane;
  logic [3:0]  port_be;
  logic [31:0] port_wdata;
  logic        port_ack = 1'b0;
  logic [31:0] port_rdata = '0;
  logic        done, done_status;
  logic [31:0] done_rdata;

  int checks = 0, errors = 0;

  // transaction log filled by the port model
  int          lg_n = 0;
  logic        lg_sel[4], lg_wr[4];
  logic [31:0] lg_wd[4], lg_rd[4];
  logic [3:0]  lg_be[4];
  logic [1:0]  lg_lane[4];

  logic [5:0]  cur_mode = '0;
  logic [7:0]  cur_root = '0, cur_own = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_indirect_engine i_cfg_indirect_engine (.*);

  // downstream register model with random wait states
  always @(negedge clk) begin
    port_ack = 1'b0;
    if (port_valid && ($urandom % 3 != 0)) begin
      port_ack   = 1'b1;
      port_rdata = $urandom;
      if (lg_n < 4) begin
        lg_sel[lg_n]  = port_sel;
        lg_wr[lg_n]   = port_write;
        lg_wd[lg_n]   = port_wdata;
        lg_be[lg_n]   = port_be;
        lg_lane[lg_n] = port_lane;
        lg_rd[lg_n]   = port_rdata;
      end
      lg_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [5:0] m, input logic [7:0] own, input logic [7:0] root,
                                           input logic [7:0] bus, input logic [7:0] devfn, input logic [11:0] off);
    logic [31:0] w;
    logic [7:0]  b;
    b = (bus == root) ? own : bus;
    w = 32'h8000_0000 | (32'(b) << 16) | (32'(devfn) << 8) | (32'(off) & 32'hFC);
    if (m[0]) w = w | ((32'(off) >> 8) << 24);
    if (m[1] && bus != root) w = w | 32'd1;
    if (m[2]) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
    return w;
  endfunction

  function automatic logic [31:0] exp_mask(input logic [2:0] len);
    if (len == 3'd1) return 32'hFF;
    if (len == 3'd2) return 32'hFFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] exp_be(input logic [2:0] len, input logic [1:0] lane);
    logic [7:0] s;
    s = (len == 3'd1) ? 8'h1 : (len == 3'd2) ? 8'h3 : 8'hF;
    s = s << lane;
    return s[3:0];
  endfunction

  function automatic logic [31:0] exp_wd(input logic [5:0] m, input logic root_hit, input logic [11:0] off,
                                         input logic [31:0] d);
    if (m[5] && off == 12'h00C) d = 32'h0;
    if (m[4] && root_hit && off == 12'h018) d = d & 32'hFFFF_FF00;
    return d << (8 * off[1:0]);
  endfunction

  task automatic load_mode(input logic [5:0] m, input logic [7:0] root, input logic [7:0] own);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_load = 1'b1; cfg_mode = m; cfg_root_bus = root; cfg_own_bus = own;
    @(negedge clk);
    cfg_load = 1'b0;
    cur_mode = m; cur_root = root; cur_own = own;
  endtask

  task automatic run_req(input logic w, input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [11:0] off, input logic [2:0] len, input logic [31:0] d,
                         input bit poke);
    bit          rej, root_hit, got;
    logic [31:0] ea, er;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lg_n = 0;
    req_valid = 1'b1; req_write = w; req_bus = bus; req_devfn = devfn;
    req_offset = off; req_len = len; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8 busy after accept", 32'(req_ready), 0);
    if (poke) begin
      cfg_load = 1'b1; cfg_mode = ~cur_mode; cfg_root_bus = ~cur_root; cfg_own_bus = ~cur_own;
    end
    got = 0;
    for (int i = 0; i < 60 && !got; i++) begin
      if (done) got = 1;
      else begin
        @(negedge clk);
        cfg_load = 1'b0;
      end
    end
    cfg_load = 1'b0;
    check(got, "R8 done pulse seen", 32'(got), 1);
    root_hit = (bus == cur_root);
    rej = cur_mode[3] && (!root_hit || devfn != 0);
    check(done_status == rej, "R5 status", 32'(done_status), 32'(rej));
    if (rej) begin
      check(lg_n == 0, "R5 no port access", lg_n, 0);
      check(done_rdata == 0, "R5 rdata zero", done_rdata, 0);
    end else begin
      ea = exp_addr(cur_mode, cur_own, cur_root, bus, devfn, off);
      check(lg_n == 2, "R7 two accesses", lg_n, 2);
      check(lg_sel[0] == 0 && lg_wr[0] && lg_be[0] == 4'hF, "R7 address phase first",
            {lg_sel[0], lg_wr[0], lg_be[0]}, {2'b01, 4'hF});
      check(lg_wd[0] == ea, "R1 R2 R3 R4 R7 address word", lg_wd[0], ea);
      check(lg_sel[1] == 1 && lg_wr[1] == w, "R7 data phase", {lg_sel[1], lg_wr[1]}, {1'b1, w});
      check(lg_be[1] == exp_be(len, off[1:0]) && lg_lane[1] == off[1:0], "R6 strobe and lane",
            {lg_lane[1], lg_be[1]}, {off[1:0], exp_be(len, off[1:0])});
      if (w) begin
        er = exp_wd(cur_mode, root_hit, off, d);
        check(lg_wd[1] == er, "R6 R10 R11 write data", lg_wd[1], er);
        check(done_rdata == 0, "R6 write returns zero", done_rdata, 0);
      end else begin
        er = (lg_rd[1] >> (8 * off[1:0])) & exp_mask(len);
        check(done_rdata == er, "R6 read extraction", done_rdata, er);
      end
    end
    @(negedge clk);
    check(!done && req_ready, "R8 single pulse and ready", {done, req_ready}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0f_ee17));
    repeat (3) @(negedge clk);
    check(req_ready && !done && !port_valid && !done_status, "R8 reset state",
          {req_ready, done, port_valid, done_status}, 4'b1000);
    rst_n = 1'b1;

    // R1 R4 plain, root substitution and non-root bus
    load_mode(6'b000000, 8'h00, 8'h40);
    run_req(0, 8'h00, 8'h08, 12'h004, 3'd4, 0, 0);
    run_req(0, 8'h05, 8'h11, 12'h0FC, 3'd4, 0, 0);
    // R2 extended register bits, R3 type1 marking
    load_mode(6'b000011, 8'h02, 8'h07);
    run_req(0, 8'h09, 8'h00, 12'hA5C, 3'd4, 0, 0);
    run_req(0, 8'h02, 8'h00, 12'h35C, 3'd4, 0, 0);
    // R7 big-endian address word, data stays little-endian
    load_mode(6'b000100, 8'h00, 8'h00);
    run_req(1, 8'h03, 8'h21, 12'h012, 3'd2, 32'h0000_BEEF, 0);
    // R6 byte lane 3, halfword lane 2, odd lengths
    run_req(0, 8'h03, 8'h21, 12'h013, 3'd1, 0, 0);
    run_req(0, 8'h03, 8'h21, 12'h042, 3'd2, 0, 0);
    run_req(1, 8'h03, 8'h21, 12'h041, 3'd1, 32'h0000_00A5, 0);
    run_req(0, 8'h03, 8'h21, 12'h040, 3'd0, 0, 0);
    run_req(1, 8'h03, 8'h21, 12'h043, 3'd2, 32'h0000_1234, 0);
    // R5 no-link filtering
    load_mode(6'b001000, 8'h04, 8'h01);
    run_req(0, 8'h04, 8'h00, 12'h000, 3'd4, 0, 0);
    run_req(0, 8'h04, 8'h08, 12'h000, 3'd4, 0, 0);
    run_req(1, 8'h05, 8'h00, 12'h000, 3'd4, 32'hFFFF_FFFF, 0);
    // R10 primary clear: root bus hit, non-root miss; R11 cache line zero
    load_mode(6'b110000, 8'h00, 8'h00);
    run_req(1, 8'h00, 8'h00, 12'h018, 3'd4, 32'h0012_3456, 0);
    run_req(1, 8'h00, 8'h00, 12'h018, 3'd1, 32'h0000_00AB, 0);
    run_req(1, 8'h06, 8'h00, 12'h018, 3'd4, 32'h0012_3456, 0);
    run_req(1, 8'h06, 8'h00, 12'h00C, 3'd4, 32'hCAFE_F00D, 0);
    run_req(1, 8'h06, 8'h00, 12'h00D, 3'd1, 32'h0000_0055, 0);
    load_mode(6'b000000, 8'h00, 8'h00);
    run_req(1, 8'h00, 8'h00, 12'h00C, 3'd4, 32'hCAFE_F00D, 0);
    // R9 load presented while busy is ignored for this and the next request
    load_mode(6'b000111, 8'h01, 8'h09);
    run_req(0, 8'h03, 8'h10, 12'h804, 3'd4, 0, 1);
    run_req(0, 8'h01, 8'h10, 12'h808, 3'd4, 0, 0);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] b, df;
      logic [11:0] o;
      int pick;
      if (n % 25 == 0) load_mode(6'($urandom), 8'($urandom % 4), 8'($urandom));
      b  = ($urandom % 2) ? cur_root : 8'($urandom % 8);
      df = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      pick = $urandom % 6;
      o  = (pick == 0) ? 12'h018 : (pick == 1) ? 12'h00C : 12'($urandom);
      run_req(1'($urandom), b, df, o, 3'($urandom % 5), $urandom, ($urandom % 10 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule